// File: doc/BRIEF.md
# Configurable External Interrupt Forwarder

This block accepts a bank of external interrupt lines and turns each one into an active-high level request. Each request drives its own output toward a downstream interrupt controller. Every line is configured on its own. It can follow the input level or catch an edge, and it can respond to the high/rising or the low/falling sense of the input. Each input passes through a two-flop synchroniser before detection. Edge events are latched until software clears them by writing a one to the clear register. A per-line mask gates the outputs, and a separate raw view shows the latched requests whether they are masked or not.

Software reaches the block through a plain 32-bit register port (write enable, byte address, write data, combinational read data) that decodes a 0x20-byte window of eight word registers. The usual bring-up sequence is as follows. Clear every line and mask every line. Program the sense and detection mode. Clear again to drop anything picked up while reconfiguring. Then unmask.

Top module: `xirq_fwd`

## Requirements
- R1: After reset the mask register (0x00) reads all ones, the source-select (0x04), polarity (0x14), edge (0x18) and spare (0x1C) registers read zero, and every output is low.
- R2: A mask bit of 1 blocks its line and 0 passes it. The request status register (0x08) reads raw AND NOT mask, and each output equals its request status bit.
- R3: The raw status register (0x0C) shows each line's latched request whether or not the line is masked.
- R4: With edge bit 0 (0x18), a line is in level mode. Its request follows the qualified input with a latency of exactly three clock edges: two synchroniser stages and one request register.
- R5: A polarity bit of 1 (0x14) qualifies the input as active-high level or rising edge. A polarity bit of 0 qualifies it as active-low level or falling edge.
- R6: With edge bit 1, a line's request sets on a qualified edge three clock edges after the input changes. The request then holds after the input returns, until it is cleared.
- R7: Writing 1 to a bit of the clear register (0x10) drops that line's edge-latched request at the write edge. Writing 0 leaves the request unchanged. The clear register reads as zero.
- R8: When a clear write and a newly detected edge hit the same line in the same cycle, the edge wins and the request stays set.
- R9: Source select (0x04) and spare (0x1C) are read/write storage. Writing them changes neither the outputs nor any request.
- R10: Writes to the read-only status registers (0x08, 0x0C) and to any address whose two low bits are not zero are ignored, and such unaligned reads return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_irq | input | NLINES | Asynchronous external interrupt inputs |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Byte address within the 0x20-byte window |
| wdata | input | DATA_W | Register write data |
| rdata | output | DATA_W | Read data for the register at addr |
| irq_out | output | NLINES | Active-high level requests toward the interrupt controller |

## Verification
The collision that matters is a software clear and a fresh edge landing on the same line in the same cycle. A lost event there would stay lost. The bench raises an edge-mode input and issues the clear write on the third edge after the input change, which is exactly when the detector fires. The raw status must still read one for that line, and a second clear with no edge must then drop it. Beyond that single case, a behavioural model tracks every line on every cycle while pseudo-random inputs and clear writes run. This lets any other coincidence of clear and detection be judged at the outputs and at the status reads.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
   localparam int ADDR_W = 5;

   // Word index = addr[4:2]; offsets are what software programs against
   typedef enum logic [2:0] {
      RG_MASK  = 3'd0,
      RG_SRC   = 3'd1,
      RG_REQ   = 3'd2,
      RG_RAW   = 3'd3,
      RG_CLR   = 3'd4,
      RG_POL   = 3'd5,
      RG_EDGE  = 3'd6,
      RG_SPARE = 3'd7
   } xirq_reg_e;
endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("xirq_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) stg[k] <= '0;
      end else begin
         stg[0] <= d;
         for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/xirq_line.sv
module xirq_line (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_in,
   input  logic pol_hi,
   input  logic edge_mode,
   input  logic clr,
   output logic req
);
   logic qual;
   logic qual_d;
   logic det;

   always_comb begin
      qual = pol_hi ? sync_in : ~sync_in;
      det  = qual & ~qual_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         qual_d <= 1'b0;
         req    <= 1'b0;
      end else begin
         qual_d <= qual;
         if (edge_mode) req <= det | (req & ~clr);
         else           req <= qual;
      end
   end

   // R6
   edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode && req && !clr) |=> req);

   // R7
   edge_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode && clr && !det) |=> !req);

   // R8
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode && det) |=> req);

   // R4
   level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !edge_mode |=> (req == $past(qual)));
endmodule

// File: rtl/xirq_regs.sv
module xirq_regs
   import xirq_pkg::*;
#(
   parameter int NLINES = 32,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [NLINES-1:0] raw,
   output logic [NLINES-1:0] mask,
   output logic [NLINES-1:0] pol,
   output logic [NLINES-1:0] edge_sel,
   output logic [NLINES-1:0] clr,
   output logic [DATA_W-1:0] rdata
);
   logic [NLINES-1:0] src_q;
   logic [NLINES-1:0] spare_q;
   logic              hit;
   xirq_reg_e         word;
   logic [NLINES-1:0] wbits;

   assign hit   = (addr[1:0] == 2'b00);
   assign word  = xirq_reg_e'(addr[4:2]);
   assign wbits = wdata[NLINES-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask     <= '1;
         src_q    <= '0;
         pol      <= '0;
         edge_sel <= '0;
         spare_q  <= '0;
      end else if (wr_en && hit) begin
         case (word)
            RG_MASK:  mask     <= wbits;
            RG_SRC:   src_q    <= wbits;
            RG_POL:   pol      <= wbits;
            RG_EDGE:  edge_sel <= wbits;
            RG_SPARE: spare_q  <= wbits;
            default:  ;
         endcase
      end
   end

   assign clr = (wr_en && hit && word == RG_CLR) ? wbits : '0;

   always_comb begin
      rdata = '0;
      if (hit) begin
         case (word)
            RG_MASK:  rdata[NLINES-1:0] = mask;
            RG_SRC:   rdata[NLINES-1:0] = src_q;
            RG_REQ:   rdata[NLINES-1:0] = raw & ~mask;
            RG_RAW:   rdata[NLINES-1:0] = raw;
            RG_POL:   rdata[NLINES-1:0] = pol;
            RG_EDGE:  rdata[NLINES-1:0] = edge_sel;
            RG_SPARE: rdata[NLINES-1:0] = spare_q;
            default:  rdata = '0;
         endcase
      end
   end

   // R2
   mask_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && hit && word == RG_MASK) |=> (mask == $past(wbits)));

   // R10
   ro_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (!hit || word == RG_REQ || word == RG_RAW)) |=>
         ($stable(mask) && $stable(pol) && $stable(edge_sel)));
endmodule

// File: rtl/xirq_fwd.sv
module xirq_fwd
   import xirq_pkg::*;
#(
   parameter int NLINES      = 32,
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NLINES-1:0] ext_irq,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [NLINES-1:0] irq_out
);
   if (NLINES < 1 || NLINES > DATA_W) begin : g_bad_lines
      $error("xirq_fwd: NLINES must be within 1..DATA_W");
   end

   logic [NLINES-1:0] sync_q;
   logic [NLINES-1:0] raw;
   logic [NLINES-1:0] mask;
   logic [NLINES-1:0] pol;
   logic [NLINES-1:0] edge_sel;
   logic [NLINES-1:0] clr;

   xirq_sync #(.W(NLINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (ext_irq),
      .q     (sync_q)
   );

   xirq_regs #(.NLINES(NLINES), .DATA_W(DATA_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .addr     (addr),
      .wdata    (wdata),
      .raw      (raw),
      .mask     (mask),
      .pol      (pol),
      .edge_sel (edge_sel),
      .clr      (clr),
      .rdata    (rdata)
   );

   for (genvar i = 0; i < NLINES; i++) begin : g_line
      xirq_line u_line (
         .clk       (clk),
         .rst_n     (rst_n),
         .sync_in   (sync_q[i]),
         .pol_hi    (pol[i]),
         .edge_mode (edge_sel[i]),
         .clr       (clr[i]),
         .req       (raw[i])
      );
   end

   assign irq_out = raw & ~mask;
endmodule

// File: tb/tb_xirq_fwd.sv
module tb_xirq_fwd;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [4:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] ext = '0;
   logic [31:0] rdata;
   logic [31:0] irq;

   int checks = 0;
   int fails  = 0;

   // behavioural reference state
   logic [31:0] m_s1 = '0, m_s2 = '0, m_qd = '0, m_raw = '0;
   logic [31:0] m_mask = '1, m_src = '0, m_pol = '0, m_edge = '0, m_spare = '0;
   logic [31:0] lfsr = 32'hACE1_2468;

   always #4 clk = ~clk;

   xirq_fwd dut (
      .clk(clk), .rst_n(rst_n), .ext_irq(ext), .wr_en(wr_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq)
   );

   initial begin
      #(8 * 200000);
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   function automatic logic [31:0] m_read(input logic [4:0] a);
      if (a[1:0] != 2'b00) return '0;
      case (a[4:2])
         3'd0: return m_mask;
         3'd1: return m_src;
         3'd2: return m_raw & ~m_mask;
         3'd3: return m_raw;
         3'd5: return m_pol;
         3'd6: return m_edge;
         3'd7: return m_spare;
         default: return '0;
      endcase
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick(input string tag);
      logic [31:0] clrv, q, det, rn;
      clrv = (wr_en && addr == 5'h10) ? wdata : '0;
      for (int i = 0; i < 32; i++) begin
         q[i]   = m_pol[i] ? m_s2[i] : ~m_s2[i];
         det[i] = q[i] & ~m_qd[i];
         rn[i]  = m_edge[i] ? (det[i] | (m_raw[i] & ~clrv[i])) : q[i];
      end
      @(posedge clk);
      if (!rst_n) begin
         m_s1 = '0; m_s2 = '0; m_qd = '0; m_raw = '0;
         m_mask = '1; m_src = '0; m_pol = '0; m_edge = '0; m_spare = '0;
      end else begin
         m_s2 = m_s1; m_s1 = ext; m_qd = q; m_raw = rn;
         if (wr_en && addr[1:0] == 2'b00) begin
            case (addr[4:2])
               3'd0: m_mask  = wdata;
               3'd1: m_src   = wdata;
               3'd5: m_pol   = wdata;
               3'd6: m_edge  = wdata;
               3'd7: m_spare = wdata;
               default: ;
            endcase
         end
      end
      @(negedge clk);
      check({tag, " R2 irq_out"}, irq, m_raw & ~m_mask);
      check({tag, " rdata"}, rdata, m_read(addr));
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d, input string tag);
      logic [4:0] keep;
      keep = addr;
      wr_en = 1'b1; addr = a; wdata = d;
      tick(tag);
      wr_en = 1'b0; addr = keep; wdata = '0;
   endtask

   task automatic ticks(input int n, input string tag);
      for (int k = 0; k < n; k++) tick(tag);
   endtask

   initial begin
      @(negedge clk);
      ticks(3, "R1 reset");
      check("R1 mask reset", rdata, 32'hFFFF_FFFF);
      check("R1 outputs low", irq, 32'h0);
      rst_n = 1'b1;
      for (int k = 1; k < 8; k++) begin
         addr = 5'(k * 4);
         tick("R1 post-reset read");
      end
      addr = 5'h00;

      // bring-up
      wr(5'h10, 32'hFFFF_FFFF, "R7 clear all");
      wr(5'h00, 32'hFFFF_FFFF, "R2 mask all");
      wr(5'h14, 32'h0000_FFFF, "R5 polarity");
      wr(5'h18, 32'h00FF_00FF, "R6 edge select");
      ext = 32'h0000_0000;
      ticks(4, "R5 settle");
      wr(5'h10, 32'hFFFF_FFFF, "R7 clear after config");
      wr(5'h00, 32'h0000_0000, "R2 unmask");

      // pseudo-random traffic with interleaved clears
      for (int c = 0; c < 60; c++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         ext  = lfsr;
         addr = c[0] ? 5'h0C : 5'h08;
         if (c % 7 == 3) wr(5'h10, lfsr ^ 32'h5A5A_5A5A, "R7 random clear");
         else tick("R3 random traffic");
      end

      // level high latency, line 8
      ext = 32'h0000_0000;
      ticks(4, "R4 settle");
      wr(5'h10, 32'hFFFF_FFFF, "R7 clear");
      ext[8] = 1'b1;
      ticks(2, "R4 latency");
      check("R4 line8 not yet", {31'b0, irq[8]}, 32'd0);
      tick("R4 latency");
      check("R4 line8 follows", {31'b0, irq[8]}, 32'd1);
      ext[8] = 1'b0;
      ticks(3, "R4 release");
      check("R4 line8 drops", {31'b0, irq[8]}, 32'd0);

      // level low, line 24
      ext[24] = 1'b1;
      ticks(3, "R5 low level");
      check("R5 line24 inactive high", {31'b0, irq[24]}, 32'd0);
      ext[24] = 1'b0;
      ticks(3, "R5 low level");
      check("R5 line24 active low", {31'b0, irq[24]}, 32'd1);

      // falling edge, line 16
      ext[16] = 1'b1;
      ticks(4, "R5 falling prep");
      wr(5'h10, 32'h0001_0000, "R7 clear line16");
      check("R7 line16 cleared", {31'b0, irq[16]}, 32'd0);
      ext[16] = 1'b0;
      ticks(3, "R5 falling edge");
      check("R5 line16 falling edge", {31'b0, irq[16]}, 32'd1);
      ext[16] = 1'b1;
      ticks(4, "R6 hold");
      check("R6 line16 held", {31'b0, irq[16]}, 32'd1);
      wr(5'h10, 32'h0000_0000, "R7 zero clear");
      check("R7 zero write keeps line16", {31'b0, irq[16]}, 32'd1);
      addr = 5'h10;
      tick("R7 clear reads zero");
      check("R7 clear reads zero", rdata, 32'h0);

      // masked edge still latched in raw, line 4
      wr(5'h00, 32'hF0F0_F0F0, "R2 partial mask");
      ext[4] = 1'b1;
      ticks(3, "R3 masked edge");
      addr = 5'h0C;
      tick("R3 raw read");
      check("R3 raw shows masked line4", {31'b0, rdata[4]}, 32'd1);
      check("R2 masked line4 output", {31'b0, irq[4]}, 32'd0);
      addr = 5'h08;
      tick("R2 req read");
      check("R2 req hides line4", {31'b0, rdata[4]}, 32'd0);

      // clear and edge in the same cycle, line 0 (unmasked, rising)
      ext[0] = 1'b0;
      ticks(4, "R8 prep");
      wr(5'h10, 32'h0000_0001, "R8 prep clear");
      ext[0] = 1'b1;
      ticks(2, "R8 approach");
      wr(5'h10, 32'h0000_0001, "R8 collide");
      addr = 5'h0C;
      tick("R8 after");
      check("R8 edge wins over clear", {31'b0, rdata[0]}, 32'd1);
      check("R8 output set", {31'b0, irq[0]}, 32'd1);
      wr(5'h10, 32'h0000_0001, "R7 clear w/o edge");
      check("R7 line0 dropped", {31'b0, rdata[0]}, 32'd0);

      // storage registers
      wr(5'h04, 32'hA5A5_A5A5, "R9 src write");
      wr(5'h1C, 32'h1234_5678, "R9 spare write");
      addr = 5'h04;
      tick("R9 read");
      check("R9 src readback", rdata, 32'hA5A5_A5A5);
      addr = 5'h1C;
      tick("R9 read");
      check("R9 spare readback", rdata, 32'h1234_5678);

      // ignored writes
      wr(5'h08, 32'hFFFF_FFFF, "R10 req write");
      wr(5'h0C, 32'hFFFF_FFFF, "R10 raw write");
      wr(5'h02, 32'h0000_0000, "R10 unaligned write");
      addr = 5'h00;
      tick("R10 read");
      check("R10 mask unchanged", rdata, 32'hF0F0_F0F0);
      addr = 5'h01;
      tick("R10 unaligned read");
      check("R10 unaligned reads zero", rdata, 32'h0);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule